// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block tracks one reservation for a single hart. A load-reserved request issues one load and records the reserved location as a granule tag plus a byte mask. A later store-conditional succeeds only if that reservation is still live and names the same bytes. Only a successful conditional drives the memory store enable. Every conditional, whether it passes or not, clears the reservation.

A separate snoop port carries stores from other harts. A remote store that touches any reserved byte cancels the reservation, so the next conditional fails. The block reports a pass/fail code for the destination register one cycle after each request. It suppresses the register write when the destination is register zero. Memory contents and any timeout policy live outside this block.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held, and a store-conditional issued first fails with no store enable.
- R2: A load-reserved gives exactly one `mem_ld_en` pulse and one `rsp_valid` pulse, one cycle after the request, and it arms the reservation.
- R3: A store-conditional whose address and size equal those of the live reservation responds one cycle later with `rsp_fail`=0 (success) and a one-cycle `mem_st_en` pulse.
- R4: A store-conditional with no live reservation, a different address, or a different size responds with `rsp_fail`=1 (failure) and no `mem_st_en`.
- R5: Every store-conditional clears the reservation whether it succeeds or fails, so a second conditional to the same location fails.
- R6: A newer load-reserved replaces the older reservation. A conditional to the new location succeeds, and one to the old location fails.
- R7: A snooped remote store cancels the reservation only when its granule matches and its byte mask shares at least one byte with the reserved mask. Disjoint bytes in the same granule, or a different granule, leave the reservation intact.
- R8: The access size codes are 0, 1, 2 and 3, meaning 1, 2, 4 and 8 bytes. The mask starts at the byte offset given by the low three address bits of an 8-byte granule.
- R9: When a snoop hit and a store-conditional arrive in the same cycle, the conditional fails. When an overlapping snoop and a load-reserved arrive in the same cycle, the new reservation stays armed.
- R10: `rsp_rd_we` is 1 only in the response to a store-conditional whose `req_rd` is nonzero. With destination 0, no register write happens, but a successful store still asserts `mem_st_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_is_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_rd | input | 5 | Destination register index |
| snp_valid | input | 1 | Remote store strobe |
| snp_addr | input | 32 | Remote store byte address |
| snp_size | input | 2 | Remote store size code |
| rsp_valid | output | 1 | Response strobe, one cycle after each request |
| rsp_is_sc | output | 1 | Response belongs to a store-conditional |
| rsp_rd | output | 5 | Destination register index echoed |
| rsp_rd_we | output | 1 | Write pass/fail code to the destination register |
| rsp_fail | output | 1 | 0 = success, 1 = failure |
| mem_ld_en | output | 1 | Load enable for a load-reserved |
| mem_st_en | output | 1 | Store enable for a successful conditional |

## Verification
Every result is registered once. The response strobe, the pass/fail code, the write enable and both memory enables all appear in the cycle after the request edge. A snoop changes only state, so its effect shows up through the next conditional's response one cycle after that conditional. The bench drives inputs on the falling edge and samples on the following falling edge, one rising edge later, which is the single cycle where each result is due. It also confirms that the strobes drop again in the next cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int ADDR_W_DEF = 32;
  localparam int GRAN_DEF   = 8;
  localparam int RD_W_DEF   = 5;
  localparam int SIZE_W     = 2;

  localparam logic CODE_PASS = 1'b0;
  localparam logic CODE_FAIL = 1'b1;

  typedef enum logic [SIZE_W-1:0] {
    ACC_B = 2'd0,
    ACC_H = 2'd1,
    ACC_W = 2'd2,
    ACC_D = 2'd3
  } acc_size_e;
endpackage

// File: rtl/rsv_byte_mask.sv
module rsv_byte_mask #(
  parameter int ADDR_W = 32,
  parameter int GRAN   = 8,
  localparam int OFS_W = $clog2(GRAN),
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [rsv_pkg::SIZE_W-1:0] size_i,
  output logic [TAG_W-1:0]           tag_o,
  output logic [GRAN-1:0]            mask_o
);
  localparam int CW = OFS_W + 5;

  logic [CW-1:0] lo;
  logic [CW-1:0] hi;

  assign tag_o = addr_i[ADDR_W-1:OFS_W];

  always_comb begin
    lo = CW'(addr_i[OFS_W-1:0]);
    hi = lo + (CW'(1) << size_i);
  end

  for (genvar b = 0; b < GRAN; b++) begin : g_byte
    assign mask_o[b] = (CW'(b) >= lo) && (CW'(b) < hi);
  end
endmodule

// File: rtl/rsv_overlap.sv
module rsv_overlap #(
  parameter int TAG_W = 29,
  parameter int GRAN  = 8
) (
  input  logic [TAG_W-1:0] tag_a_i,
  input  logic [GRAN-1:0]  mask_a_i,
  input  logic [TAG_W-1:0] tag_b_i,
  input  logic [GRAN-1:0]  mask_b_i,
  output logic             hit_o
);
  assign hit_o = (tag_a_i == tag_b_i) && (|(mask_a_i & mask_b_i));
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry #(
  parameter int TAG_W = 29,
  parameter int GRAN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             kill_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [GRAN-1:0]  mask_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [GRAN-1:0]  mask_o
);
  logic             valid_d;
  logic [TAG_W-1:0] tag_d;
  logic [GRAN-1:0]  mask_d;

  always_comb begin
    valid_d = valid_o;
    tag_d   = tag_o;
    mask_d  = mask_o;
    if (set_i) begin
      valid_d = 1'b1;
      tag_d   = tag_i;
      mask_d  = mask_i;
    end else if (clr_i || kill_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      mask_o  <= '0;
    end else begin
      valid_o <= valid_d;
      if (set_i) begin
        tag_o  <= tag_d;
        mask_o <= mask_d;
      end
    end
  end

  assert_lr_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> valid_o);
  assert_sc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !valid_o);
  assert_snoop_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && !set_i) |=> !valid_o);
  assert_hold_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> ($stable(tag_o) && $stable(mask_o)));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int ADDR_W = rsv_pkg::ADDR_W_DEF,
  parameter int GRAN   = rsv_pkg::GRAN_DEF,
  parameter int RD_W   = rsv_pkg::RD_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_is_sc,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [rsv_pkg::SIZE_W-1:0] req_size,
  input  logic [RD_W-1:0]            req_rd,
  input  logic                       snp_valid,
  input  logic [ADDR_W-1:0]          snp_addr,
  input  logic [rsv_pkg::SIZE_W-1:0] snp_size,
  output logic                       rsp_valid,
  output logic                       rsp_is_sc,
  output logic [RD_W-1:0]            rsp_rd,
  output logic                       rsp_rd_we,
  output logic                       rsp_fail,
  output logic                       mem_ld_en,
  output logic                       mem_st_en
);
  localparam int OFS_W = $clog2(GRAN);
  localparam int TAG_W = ADDR_W - OFS_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [TAG_W-1:0] req_tag, snp_tag, rsv_tag;
  logic [GRAN-1:0]  req_mask, snp_mask, rsv_mask;
  logic             rsv_valid, snp_hit_raw, snp_hit;
  logic             req_lr, req_sc, sc_match, sc_ok;

  rsv_byte_mask #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_req_mask (
    .addr_i(req_addr), .size_i(req_size), .tag_o(req_tag), .mask_o(req_mask));

  rsv_byte_mask #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_snp_mask (
    .addr_i(snp_addr), .size_i(snp_size), .tag_o(snp_tag), .mask_o(snp_mask));

  rsv_overlap #(.TAG_W(TAG_W), .GRAN(GRAN)) u_snp_ovl (
    .tag_a_i(snp_tag), .mask_a_i(snp_mask),
    .tag_b_i(rsv_tag), .mask_b_i(rsv_mask), .hit_o(snp_hit_raw));

  always_comb begin
    req_lr   = req_valid && !req_is_sc;
    req_sc   = req_valid && req_is_sc;
    snp_hit  = snp_valid && rsv_valid && snp_hit_raw;
    sc_match = rsv_valid && (req_tag == rsv_tag) && (req_mask == rsv_mask);
    sc_ok    = req_sc && sc_match && !snp_hit;
  end

  rsv_entry #(.TAG_W(TAG_W), .GRAN(GRAN)) u_entry (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(req_lr), .clr_i(req_sc), .kill_i(snp_hit),
    .tag_i(req_tag), .mask_i(req_mask),
    .valid_o(rsv_valid), .tag_o(rsv_tag), .mask_o(rsv_mask));

  // response stage: next-state then registers
  logic            vld_d, vld_q, ld_d, ld_q, st_d, st_q;
  logic            sc_d, sc_q, we_d, we_q, fail_d, fail_q;
  logic [RD_W-1:0] rd_d, rd_q;

  always_comb begin
    vld_d  = req_valid;
    ld_d   = req_lr;
    st_d   = sc_ok;
    sc_d   = req_is_sc;
    rd_d   = req_rd;
    we_d   = req_sc && (req_rd != '0);
    fail_d = req_sc && !sc_ok ? rsv_pkg::CODE_FAIL : rsv_pkg::CODE_PASS;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      ld_q   <= 1'b0;
      st_q   <= 1'b0;
      sc_q   <= 1'b0;
      we_q   <= 1'b0;
      fail_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      vld_q <= vld_d;
      ld_q  <= ld_d;
      st_q  <= st_d;
      if (req_valid) begin
        sc_q   <= sc_d;
        we_q   <= we_d;
        fail_q <= fail_d;
        rd_q   <= rd_d;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_is_sc = sc_q;
  assign rsp_rd    = rd_q;
  assign rsp_rd_we = vld_q && we_q;
  assign rsp_fail  = fail_q;
  assign mem_ld_en = ld_q;
  assign mem_st_en = st_q;

  assert_store_only_on_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_st_en |-> (rsp_valid && rsp_is_sc && rsp_fail == rsv_pkg::CODE_PASS));
  assert_no_rsv_no_store_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_sc && !rsv_valid) |=> !mem_st_en);
  assert_ld_st_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_ld_en && mem_st_en));
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  assert_snoop_race_fails_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_sc && snp_hit) |=> (rsp_fail == rsv_pkg::CODE_FAIL && !mem_st_en));
  assert_x0_no_write_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_rd_we |-> (rsp_is_sc && rsp_rd != '0));
endmodule

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_sc, snp_valid;
  logic [31:0] req_addr, snp_addr;
  logic [1:0]  req_size, snp_size;
  logic [4:0]  req_rd;
  logic        rsp_valid, rsp_is_sc, rsp_rd_we, rsp_fail, mem_ld_en, mem_st_en;
  logic [4:0]  rsp_rd;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rsv_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_is_sc(req_is_sc), .req_addr(req_addr),
    .req_size(req_size), .req_rd(req_rd),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_size(snp_size),
    .rsp_valid(rsp_valid), .rsp_is_sc(rsp_is_sc), .rsp_rd(rsp_rd),
    .rsp_rd_we(rsp_rd_we), .rsp_fail(rsp_fail),
    .mem_ld_en(mem_ld_en), .mem_st_en(mem_st_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_is_sc = 0; req_addr = 0; req_size = 0; req_rd = 0;
    snp_valid = 0; snp_addr = 0; snp_size = 0;
  endtask

  // issue load-reserved; check response next cycle
  task automatic lr(input logic [31:0] a, input logic [1:0] s, input string req);
    req_valid = 1; req_is_sc = 0; req_addr = a; req_size = s; req_rd = 5'd3;
    @(negedge clk);
    idle();
    chk({req, " ld_en"}, mem_ld_en, 1);
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " st_en"}, mem_st_en, 0);
  endtask

  // issue store-conditional; check pass/fail, store and write enable
  task automatic sc(input logic [31:0] a, input logic [1:0] s, input logic [4:0] rd,
                    input bit pass, input string req);
    req_valid = 1; req_is_sc = 1; req_addr = a; req_size = s; req_rd = rd;
    @(negedge clk);
    idle();
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " fail"}, rsp_fail, pass ? 0 : 1);
    chk({req, " st_en"}, mem_st_en, pass ? 1 : 0);
    chk({req, " rd_we"}, rsp_rd_we, (rd != 0) ? 1 : 0);
    @(negedge clk);
    chk({req, " st_en drops"}, mem_st_en, 0);
  endtask

  task automatic snoop(input logic [31:0] a, input logic [1:0] s);
    snp_valid = 1; snp_addr = a; snp_size = s;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid idle", rsp_valid, 0);
    chk("R1 st_en idle", mem_st_en, 0);
    sc(32'h100, 2'd2, 5'd5, 0, "R1 sc after reset");
  endtask

  task automatic t_basic();
    lr(32'h100, 2'd2, "R2 lr");
    @(negedge clk);
    chk("R2 single ld pulse", mem_ld_en, 0);
    sc(32'h100, 2'd2, 5'd5, 1, "R3 matching sc");
    sc(32'h100, 2'd2, 5'd5, 0, "R5 second sc");
  endtask

  task automatic t_mismatch();
    lr(32'h100, 2'd2, "R4 lr");
    sc(32'h104, 2'd2, 5'd6, 0, "R4 other address");
    lr(32'h100, 2'd2, "R4 lr2");
    sc(32'h100, 2'd1, 5'd6, 0, "R4 other size");
    lr(32'h100, 2'd2, "R5 lr");
    sc(32'h108, 2'd2, 5'd6, 0, "R5 failing sc");
    sc(32'h100, 2'd2, 5'd6, 0, "R5 cleared by failure");
  endtask

  task automatic t_replace();
    lr(32'h200, 2'd3, "R6 lr old");
    lr(32'h300, 2'd3, "R6 lr new");
    sc(32'h300, 2'd3, 5'd7, 1, "R6 sc new");
    lr(32'h200, 2'd3, "R6 lr old2");
    lr(32'h300, 2'd3, "R6 lr new2");
    sc(32'h200, 2'd3, 5'd7, 0, "R6 sc old");
  endtask

  task automatic t_snoop();
    lr(32'h400, 2'd2, "R7 lr");
    snoop(32'h404, 2'd2);
    sc(32'h400, 2'd2, 5'd8, 1, "R7 disjoint bytes keep");
    lr(32'h400, 2'd2, "R7 lr2");
    snoop(32'h800, 2'd3);
    sc(32'h400, 2'd2, 5'd8, 1, "R7 other granule keep");
    lr(32'h400, 2'd2, "R8 lr");
    snoop(32'h403, 2'd0);
    sc(32'h400, 2'd2, 5'd8, 0, "R8 top byte overlap kills");
    lr(32'h406, 2'd1, "R8 lr half");
    snoop(32'h400, 2'd2);
    sc(32'h406, 2'd1, 5'd8, 1, "R8 half at offset 6 keep");
    lr(32'h406, 2'd1, "R8 lr half2");
    snoop(32'h400, 2'd3);
    sc(32'h406, 2'd1, 5'd8, 0, "R8 dword covers half");
  endtask

  task automatic t_race();
    lr(32'h500, 2'd2, "R9 lr");
    snp_valid = 1; snp_addr = 32'h500; snp_size = 2'd0;
    sc(32'h500, 2'd2, 5'd9, 0, "R9 sc with same-cycle snoop");
    snp_valid = 1; snp_addr = 32'h500; snp_size = 2'd2;
    lr(32'h500, 2'd2, "R9 lr with same-cycle snoop");
    sc(32'h500, 2'd2, 5'd9, 1, "R9 lr kept");
  endtask

  task automatic t_x0();
    lr(32'h600, 2'd2, "R10 lr");
    sc(32'h600, 2'd2, 5'd0, 1, "R10 x0 pass store no write");
    sc(32'h600, 2'd2, 5'd0, 0, "R10 x0 fail no write");
    chk("R10 no rd_we idle", rsp_rd_we, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_mismatch();
    t_replace();
    t_snoop();
    t_race();
    t_x0();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule